// File: doc/BRIEF.md
# Byte-Port SPI Command Engine

This block is an SPI master that sits behind a small byte-wide register window of eight consecutive port offsets. Software fills in an opcode register, three address registers and one data register. It then writes a control byte. The control byte picks one of two SCK rates, a receive count of zero to three bytes, and an outgoing length of 1, 2, 4 or 5 bytes given as a two-bit code.

The engine drops chip select, shifts the outgoing bytes MSB first in SPI mode 0, and then clocks in the requested response bytes. It raises chip select again and clears the busy flag in the status register. Software polls that flag and then reads the response bytes back from the upper offsets.

The address registers are stored in the reverse of the order they take on the wire. The data register doubles as the third receive slot on the read side.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, MOSI is low, and offsets 0, 5, 6 and 7 all read 0x00.
- R2: A write to offset 0 while idle starts a transfer only when the upper nibble is 0x4 or 0x5. Bit 7 of offset 0 then reads 1 until the transfer ends. Any other upper nibble starts nothing.
- R3: Control bits 1:0 choose the outgoing bytes, opcode (offset 1) always first. Code 0 sends the opcode only. Code 1 adds the offset 7 write value. Code 2 adds offsets 4, 3, 2 in that order. Code 3 adds offsets 4, 3, 2 and then the offset 7 write value. Every byte is sent MSB first.
- R4: Control bits 3:2 give a receive count N from 0 to 3. N bytes are clocked after the outgoing bytes with MOSI held low. SCK pulses exactly 8 times per outgoing plus received byte.
- R5: Received bytes read back at offsets 5, 6 and 7 in wire order. Slots beyond N read 0x00, because they are cleared when a transfer starts.
- R6: SPI mode 0: SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R7: Chip select is low for the whole transfer and high when idle. It falls one SCK half-period before the first rising edge and rises one half-period after the last falling edge.
- R8: Upper nibble 0x5 runs SCK with a half-period of FAST_HALF system clocks. Upper nibble 0x4 runs it with SLOW_HALF system clocks.
- R9: While busy, writes to any offset are ignored. The running transfer is unchanged, and registers written during it keep their earlier values.
- R10: Offsets 1 to 4 read back the value last written to them while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The assertions take the following for granted:
- bus_addr and bus_wdata are valid in every cycle in which bus_we is high.
- The attached device changes MISO only while SCK is low, that is, on chip-select fall or on SCK fall.

The bench's device model drives MISO from a random 64-bit pattern only on those two events. The bench raises bus_we for exactly one clock, between falling edges. Busy-time writes are placed deliberately in the middle of a long slow transfer, so the ignore paths are exercised without breaking the input assumptions.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_OP   = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_A2   = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_A3   = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_A4   = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_RX0  = 3'd5;
  localparam logic [ADDR_W-1:0] OFF_RX1  = 3'd6;
  localparam logic [ADDR_W-1:0] OFF_DAT  = 3'd7;

  localparam logic [3:0] NIB_SLOW = 4'h4;
  localparam logic [3:0] NIB_FAST = 4'h5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOW  = 2'd1,
    SEQ_HIGH = 2'd2,
    SEQ_TAIL = 2'd3
  } seq_state_e;

  // Outgoing byte count for the two-bit length code.
  function automatic logic [2:0] out_bytes(input logic [1:0] code);
    case (code)
      2'd0:    out_bytes = 3'd1;
      2'd1:    out_bytes = 3'd2;
      2'd2:    out_bytes = 3'd4;
      default: out_bytes = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              busy,
  input  logic [3*BYTE_W-1:0] rx_bytes,
  output logic              start,
  output logic [1:0]        wcode,
  output logic [1:0]        rcnt,
  output logic              fast_req,
  output logic [BYTE_W-1:0] op_q,
  output logic [BYTE_W-1:0] a2_q,
  output logic [BYTE_W-1:0] a3_q,
  output logic [BYTE_W-1:0] a4_q,
  output logic [BYTE_W-1:0] d7_q,
  output logic [BYTE_W-1:0] bus_rdata
);
  logic              wr_ok;
  logic [BYTE_W-1:0] op_d, a2_d, a3_d, a4_d, d7_d;

  // Writes only land while idle.
  assign wr_ok    = bus_we && !busy;
  assign start    = wr_ok && (bus_addr == OFF_CTRL) &&
                    ((bus_wdata[7:4] == NIB_SLOW) || (bus_wdata[7:4] == NIB_FAST));
  assign wcode    = bus_wdata[1:0];
  assign rcnt     = bus_wdata[3:2];
  assign fast_req = bus_wdata[4];

  always_comb begin
    op_d = op_q;
    a2_d = a2_q;
    a3_d = a3_q;
    a4_d = a4_q;
    d7_d = d7_q;
    if (wr_ok) begin
      case (bus_addr)
        OFF_OP:  op_d = bus_wdata;
        OFF_A2:  a2_d = bus_wdata;
        OFF_A3:  a3_d = bus_wdata;
        OFF_A4:  a4_d = bus_wdata;
        OFF_DAT: d7_d = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      a2_q <= '0;
      a3_q <= '0;
      a4_q <= '0;
      d7_q <= '0;
    end else begin
      op_q <= op_d;
      a2_q <= a2_d;
      a3_q <= a3_d;
      a4_q <= a4_d;
      d7_q <= d7_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL: bus_rdata = {busy, 7'd0};
      OFF_OP:   bus_rdata = op_q;
      OFF_A2:   bus_rdata = a2_q;
      OFF_A3:   bus_rdata = a3_q;
      OFF_A4:   bus_rdata = a4_q;
      OFF_RX0:  bus_rdata = rx_bytes[3*BYTE_W-1 -: BYTE_W];
      OFF_RX1:  bus_rdata = rx_bytes[2*BYTE_W-1 -: BYTE_W];
      default:  bus_rdata = rx_bytes[BYTE_W-1:0];
    endcase
  end
endmodule

// File: rtl/spi_cmd_baud.sv
module spi_cmd_baud #(
  parameter int SLOW_HALF = 4,
  parameter int FAST_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CW   = $clog2(MAXH) + 1;
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_HALF - 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  generate
    if (SLOW_HALF == FAST_HALF) begin : g_one_rate
      assign lim = SLOW_LIM;
    end else begin : g_two_rate
      assign lim = fast ? FAST_LIM : SLOW_LIM;
    end
  endgenerate

  assign tick = run && (cnt_q == lim);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        wcode,
  input  logic [1:0]        rcnt,
  input  logic              fast_req,
  input  logic [BYTE_W-1:0] op,
  input  logic [BYTE_W-1:0] a2,
  input  logic [BYTE_W-1:0] a3,
  input  logic [BYTE_W-1:0] a4,
  input  logic [BYTE_W-1:0] d7,
  input  logic              tick,
  input  logic              miso,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  output logic              busy,
  output logic              fast,
  output logic [3*BYTE_W-1:0] rx_bytes
);
  localparam int TXW = 5 * BYTE_W;
  localparam int RXW = 3 * BYTE_W;
  localparam int BW  = $clog2(8 * BYTE_W) + 1;

  seq_state_e    st_q, st_d;
  logic          sck_q, sck_d, cs_q, cs_d, fast_q, fast_d;
  logic [TXW-1:0] tx_q, tx_d, tx_load;
  logic [RXW-1:0] rx_q, rx_d;
  logic [BW-1:0]  bit_q, bit_d, nbits_q, nbits_d, wbits_q, wbits_d;
  logic [4:0]     rbit;

  assign sck      = sck_q;
  assign cs_n     = cs_q;
  assign mosi     = tx_q[TXW-1];
  assign busy     = (st_q != SEQ_IDLE);
  assign fast     = fast_q;
  assign rx_bytes = rx_q;
  assign rbit     = 5'(bit_q - wbits_q);

  // Wire image, left aligned, opcode first.
  always_comb begin
    case (wcode)
      2'd0:    tx_load = {op, {(4*BYTE_W){1'b0}}};
      2'd1:    tx_load = {op, d7, {(3*BYTE_W){1'b0}}};
      2'd2:    tx_load = {op, a4, a3, a2, {BYTE_W{1'b0}}};
      default: tx_load = {op, a4, a3, a2, d7};
    endcase
  end

  always_comb begin
    st_d    = st_q;
    sck_d   = sck_q;
    cs_d    = cs_q;
    fast_d  = fast_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    bit_d   = bit_q;
    nbits_d = nbits_q;
    wbits_d = wbits_q;
    case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_d    = SEQ_LOW;
          cs_d    = 1'b0;
          sck_d   = 1'b0;
          fast_d  = fast_req;
          tx_d    = tx_load;
          rx_d    = '0;
          bit_d   = '0;
          wbits_d = BW'({out_bytes(wcode), 3'b000});
          nbits_d = BW'({out_bytes(wcode), 3'b000}) + BW'({rcnt, 3'b000});
        end
      end
      SEQ_LOW: begin
        if (tick) begin
          sck_d = 1'b1;
          st_d  = SEQ_HIGH;
          if (bit_q >= wbits_q) rx_d[5'd23 - rbit] = miso;
        end
      end
      SEQ_HIGH: begin
        if (tick) begin
          sck_d = 1'b0;
          if (bit_q == nbits_q - 1'b1) begin
            st_d = SEQ_TAIL;
            tx_d = '0;
          end else begin
            st_d  = SEQ_LOW;
            bit_d = bit_q + 1'b1;
            tx_d  = {tx_q[TXW-2:0], 1'b0};
          end
        end
      end
      default: begin
        if (tick) begin
          cs_d = 1'b1;
          st_d = SEQ_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      fast_q  <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      nbits_q <= '0;
      wbits_q <= '0;
    end else begin
      st_q    <= st_d;
      sck_q   <= sck_d;
      cs_q    <= cs_d;
      fast_q  <= fast_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      bit_q   <= bit_d;
      nbits_q <= nbits_d;
      wbits_q <= wbits_d;
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int SLOW_HALF = 4,
  parameter int FAST_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic              busy_w, start_w, fastreq_w, fast_w, tick_w;
  logic [1:0]        wcode_w, rcnt_w;
  logic [BYTE_W-1:0] opcode_w, a2_w, a3_w, a4_w, d7_w;
  logic [3*BYTE_W-1:0] rx_w;

  spi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy_w), .rx_bytes(rx_w),
    .start(start_w), .wcode(wcode_w), .rcnt(rcnt_w), .fast_req(fastreq_w),
    .op_q(opcode_w), .a2_q(a2_w), .a3_q(a3_w), .a4_q(a4_w), .d7_q(d7_w),
    .bus_rdata(bus_rdata)
  );

  spi_cmd_baud #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .fast(fast_w), .tick(tick_w)
  );

  spi_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w), .wcode(wcode_w), .rcnt(rcnt_w),
    .fast_req(fastreq_w), .op(opcode_w), .a2(a2_w), .a3(a3_w), .a4(a4_w),
    .d7(d7_w), .tick(tick_w), .miso(spi_miso), .sck(spi_sck), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .busy(busy_w), .fast(fast_w), .rx_bytes(rx_w)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi,
  input logic       busy,
  input logic       bus_we,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] op
);
  assert_sck_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));

  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  assert_go_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_we && bus_addr == 3'd0 &&
     (bus_wdata[7:4] == 4'h4 || bus_wdata[7:4] == 4'h5)) |=> busy);

  assert_op_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_addr == 3'd1) |=> $stable(op));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
  .busy(busy_w), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .op(opcode_w)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
  localparam int SLOW_HALF = 4;
  localparam int FAST_HALF = 2;
  localparam int TCLK = 8;

  logic       clk, rst_n, bus_we, spi_miso;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  spi_cmd_engine #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 0;
  always #(TCLK/2) clk = ~clk;

  // Device model.
  logic [63:0] pat, cap;
  int edges, sidx;
  time t_rise, hi_time;
  always @(negedge spi_cs_n) begin sidx = 0; spi_miso = pat[63]; end
  always @(posedge spi_sck) begin cap = {cap[62:0], spi_mosi}; edges++; t_rise = $time; end
  always @(negedge spi_sck) begin
    hi_time = $time - t_rise;
    sidx++;
    if (sidx < 64) spi_miso = pat[63 - sidx];
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd0, s);
      if (!s[7]) return;
    end
    chk("R2 busy never cleared", 1, 0);
  endtask

  function automatic int nw_of(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : 5;
  endfunction

  function automatic logic [39:0] wire_img(input logic [1:0] c, input logic [7:0] op,
      a2, a3, a4, d7);
    case (c)
      2'd0: return {op, 32'd0};
      2'd1: return {op, d7, 24'd0};
      2'd2: return {op, a4, a3, a2, 8'd0};
      default: return {op, a4, a3, a2, d7};
    endcase
  endfunction

  task automatic run_cmd(input logic [1:0] c, input logic [1:0] n, input bit f,
      input logic [7:0] op, a2, a3, a4, d7);
    int nw, tot;
    logic [63:0] mask, wbits;
    logic [7:0] r;
    nw = nw_of(c);
    tot = nw + n;
    wr(3'd1, op); wr(3'd2, a2); wr(3'd3, a3); wr(3'd4, a4); wr(3'd7, d7);
    pat = {$urandom, $urandom};
    cap = 0; edges = 0;
    wr(3'd0, {f ? 4'h5 : 4'h4, n, c});
    wait_idle();
    chk("R4 sck pulse count", edges, 8 * tot);
    mask = (64'd1 << (8 * nw)) - 1;
    wbits = (cap >> (8 * n)) & mask;
    chk("R3/R6 outgoing wire bytes", wbits, {24'd0, wire_img(c, op, a2, a3, a4, d7)} >> (40 - 8 * nw));
    chk("R4 mosi low while reading", cap & ((64'd1 << (8 * n)) - 1), 0);
    for (int k = 0; k < 3; k++) begin
      rd(3'(5 + k), r);
      if (k < n) chk("R5 received byte", r, 8'((pat >> (56 - 8 * nw - 8 * k)) & 64'hFF));
      else       chk("R5 unused slot cleared", r, 0);
    end
    chk("R8 sck half period", hi_time, (f ? FAST_HALF : SLOW_HALF) * TCLK);
    chk("R7 cs released", spi_cs_n, 1);
  endtask

  initial begin
    #(200000 * TCLK);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; spi_miso = 0; pat = 0;
    edges = 0; cap = 0; t_rise = 0; hi_time = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 cs_n", spi_cs_n, 1);
    chk("R1 sck", spi_sck, 0);
    chk("R1 mosi", spi_mosi, 0);
    rd(3'd0, r); chk("R1 status", r, 0);
    for (int k = 5; k < 8; k++) begin rd(3'(k), r); chk("R1 rx slot", r, 0); end
    // R10 readback
    wr(3'd1, 8'hA5); wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'h56);
    rd(3'd1, r); chk("R10 offset1", r, 8'hA5);
    rd(3'd2, r); chk("R10 offset2", r, 8'h12);
    rd(3'd3, r); chk("R10 offset3", r, 8'h34);
    rd(3'd4, r); chk("R10 offset4", r, 8'h56);
    // R2 invalid nibbles start nothing
    edges = 0;
    wr(3'd0, 8'h6F); repeat (4) @(negedge clk);
    rd(3'd0, r); chk("R2 nibble 6 no start", r, 0);
    wr(3'd0, 8'h0D); repeat (4) @(negedge clk);
    rd(3'd0, r); chk("R2 nibble 0 no start", r, 0);
    chk("R2 no sck after bad nibble", edges, 0);
    // Directed: all length codes and read counts
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++)
        run_cmd(2'(c), 2'(n), (c + n) % 2 == 1, 8'($urandom), 8'($urandom),
                8'($urandom), 8'($urandom), 8'($urandom));
    // R9 writes while busy are ignored
    wr(3'd1, 8'h3C); wr(3'd2, 8'h01); wr(3'd3, 8'h02); wr(3'd4, 8'h03); wr(3'd7, 8'h04);
    pat = {$urandom, $urandom}; cap = 0; edges = 0;
    wr(3'd0, 8'h4F);
    repeat (20) @(negedge clk);
    wr(3'd1, 8'hC3); wr(3'd0, 8'h50); wr(3'd4, 8'hEE);
    wait_idle();
    chk("R9 pulse count unchanged", edges, 64);
    chk("R9 opcode on wire", cap[63:56], 8'h3C);
    chk("R9 first address on wire", cap[55:48], 8'h03);
    rd(3'd1, r); chk("R9 offset1 kept", r, 8'h3C);
    rd(3'd4, r); chk("R9 offset4 kept", r, 8'h03);
    // Random mix
    for (int i = 0; i < 24; i++)
      run_cmd(2'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule